// File: doc/BRIEF.md
# Dual Countdown Timer with Interrupt Masking

This peripheral holds two identical 32-bit down-counters behind a small word-addressed register bus, plus a shared interrupt block. Each counter has a reload value (the divisor), a readable live count and a control word. The control word picks an operation (load, hold or run) and a tick source. The tick source is one of four rate-enable inputs that clock-generation logic outside the block supplies.

When a running counter receives a tick while at zero, it reloads from its divisor and raises an expiry event. Each expiry sets a sticky raw status bit. Software clears these bits by writing ones to an acknowledge location. A mask register gates the raw bits onto a single level-sensitive interrupt line. The masked view can also be read back.

Top module: `dual_countdown_timer`

## Requirements
- R1: Register byte offsets are: divisor A 0x00, count A 0x04, control A 0x08, divisor B 0x10, count B 0x14, control B 0x18, mask 0x48, acknowledge 0x4C, raw status 0x50, masked status 0x54. Divisor, control and acknowledge read as zero. Any other offset, including one that is not word aligned, reads as zero and ignores writes.
- R2: Writing a control word whose bits [1:0] are 0 (load) copies the current divisor into that counter on the same clock edge. While the counter stays in load, it does not change.
- R3: Operation code 1 (hold) freezes the counter. The reserved code 3 behaves exactly like hold.
- R4: With operation code 2 (run), the counter acts on each clock where its selected tick is high. Control bits [4:2] select the tick: code k in 4..7 uses `rate_tick[k-4]`, and codes 0..3 give no ticks. On a tick the counter decrements, except that a tick at zero reloads the divisor and counts as an expiry.
- R5: An expiry of counter A sets raw status bit 0, and an expiry of counter B sets bit 1. A raw bit stays set until it is acknowledged.
- R6: An acknowledge write clears each raw bit where the written data has a 1. Its effect is limited to that write. If an expiry and an acknowledge hit the same bit in the same cycle, the bit ends up set.
- R7: Mask bits [1:0] read back at 0x48. The masked status is raw AND mask, and `irq` is high exactly when any masked bit is set.
- R8: Synchronous reset puts both counters in hold with zero divisor, zero count and tick code 0, and clears the raw status and the mask, so `irq` is low.
- R9: A control write to a counter overrides any tick on that counter in the same cycle.
- R10: Reads are combinational from the current state. Every write and every expiry becomes visible after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (zero when not reading) |
| rate_tick | input | 4 | One tick enable per selectable rate |
| irq | output | 1 | Level interrupt, any masked status set |

## Verification
Read data is due in the same cycle the address is presented. Count changes, status bits and the interrupt level are due one rising edge after the write or tick that causes them. The bench drives each stimulus after a falling edge and compares read data and `irq` against its behavioural model shortly afterwards. It then advances the model at the rising edge using exactly the inputs it drove. As a result, every comparison sees the state after the previous edge, which is what the design presents. Directed sequences cover the same-cycle acknowledge/expiry race, the control-versus-tick override and the reserved operation code. A long random phase then mixes all register accesses with random ticks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int NUM_TMR  = 2;
    localparam int NUM_RATE = 4;
    localparam int CTRL_W   = 5;

    localparam logic [ADDR_W-1:0] TMR_STRIDE = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_DIV    = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_CNT    = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_MASK   = 8'h48;
    localparam logic [ADDR_W-1:0] OFF_ACK    = 8'h4C;
    localparam logic [ADDR_W-1:0] OFF_RAW    = 8'h50;
    localparam logic [ADDR_W-1:0] OFF_MSKD   = 8'h54;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_HOLD = 2'd1,
        OP_RUN  = 2'd2,
        OP_RSVD = 2'd3
    } tmr_op_e;

    typedef struct packed {
        logic [2:0] src;
        tmr_op_e    op;
    } tmr_ctrl_t;

    function automatic logic pick_tick(input logic [2:0] src,
                                       input logic [NUM_RATE-1:0] rates);
        return src[2] ? rates[src[1:0]] : 1'b0;
    endfunction

    function automatic logic [ADDR_W-1:0] tmr_off(input int idx,
                                                  input logic [ADDR_W-1:0] base);
        return base + ADDR_W'(idx) * TMR_STRIDE;
    endfunction
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                div_we,
    input  logic                ctrl_we,
    input  logic [W-1:0]        wdata,
    input  logic [NUM_RATE-1:0] rate_tick,
    output logic [W-1:0]        count,
    output logic                expire
);
    logic [W-1:0] div_q;
    logic [W-1:0] cnt_q;
    tmr_ctrl_t    ctrl_q;
    tmr_ctrl_t    ctrl_new;
    logic         tick;
    logic         running;

    assign ctrl_new = tmr_ctrl_t'(wdata[CTRL_W-1:0]);
    assign tick     = pick_tick(ctrl_q.src, rate_tick);
    assign running  = (ctrl_q.op == OP_RUN) && tick && !ctrl_we;
    assign expire   = running && (cnt_q == '0);
    assign count    = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            cnt_q  <= '0;
            ctrl_q <= '{src: 3'd0, op: OP_HOLD};
        end else begin
            if (div_we) begin
                div_q <= wdata;
            end
            if (ctrl_we) begin
                ctrl_q <= ctrl_new;
                if (ctrl_new.op == OP_LOAD) begin
                    cnt_q <= div_q;
                end
            end else if (running) begin
                cnt_q <= (cnt_q == '0) ? div_q : cnt_q - 1'b1;
            end
        end
    end

    // R3: hold and reserved code freeze the count
    p_hold_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        ((ctrl_q.op == OP_HOLD || ctrl_q.op == OP_RSVD) && !ctrl_we) |=> $stable(count))
        else $error("hold changed count");

    // R4: an expiry reloads the divisor
    p_expire_reload_r4: assert property (@(posedge clk) disable iff (rst)
        expire |=> (count == $past(div_q)))
        else $error("no reload on expiry");

    // R2: load write copies divisor
    p_load_copy_r2: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we && wdata[1:0] == 2'd0) |=> (count == $past(div_q)))
        else $error("load did not copy divisor");
endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mask_we,
    input  logic         ack_we,
    input  logic [N-1:0] wbits,
    input  logic [N-1:0] expire,
    output logic [N-1:0] raw,
    output logic [N-1:0] mask,
    output logic         irq
);
    logic [N-1:0] raw_q;
    logic [N-1:0] mask_q;
    logic [N-1:0] clr;

    assign clr = ack_we ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q <= (raw_q & ~clr) | expire;
            if (mask_we) begin
                mask_q <= wbits;
            end
        end
    end

    assign raw  = raw_q;
    assign mask = mask_q;
    assign irq  = |(raw_q & mask_q);

    // R5: expiry always leaves its bit set (also covers R6 race)
    p_expire_sets_r5: assert property (@(posedge clk) disable iff (rst)
        (expire != '0) |=> ((raw & $past(expire)) == $past(expire)))
        else $error("expiry lost");

    // R6: acknowledged bits without expiry are cleared
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (ack_we && (wbits & ~expire) != '0) |=> ((raw & $past(wbits & ~expire)) == '0))
        else $error("ack did not clear");

    // R7: no interrupt while mask is empty
    p_mask_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !irq)
        else $error("irq with empty mask");
endmodule

// File: rtl/dual_countdown_timer.sv
module dual_countdown_timer
    import tmr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_RATE-1:0] rate_tick,
    output logic                irq
);
    logic                wr;
    logic                rd;
    logic [NUM_TMR-1:0]  expire;
    logic [DATA_W-1:0]   count [NUM_TMR];
    logic [NUM_TMR-1:0]  raw;
    logic [NUM_TMR-1:0]  mask;
    logic                mapped;

    assign wr = bus_sel && bus_we;
    assign rd = bus_sel && !bus_we;

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        tmr_channel #(.W(DATA_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .div_we   (wr && bus_addr == tmr_off(i, OFF_DIV)),
            .ctrl_we  (wr && bus_addr == tmr_off(i, OFF_CTRL)),
            .wdata    (bus_wdata),
            .rate_tick(rate_tick),
            .count    (count[i]),
            .expire   (expire[i])
        );
    end

    tmr_irq_unit #(.N(NUM_TMR)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .mask_we(wr && bus_addr == OFF_MASK),
        .ack_we (wr && bus_addr == OFF_ACK),
        .wbits  (bus_wdata[NUM_TMR-1:0]),
        .expire (expire),
        .raw    (raw),
        .mask   (mask),
        .irq    (irq)
    );

    always_comb begin
        bus_rdata = '0;
        mapped    = 1'b0;
        if (rd) begin
            for (int i = 0; i < NUM_TMR; i++) begin
                if (bus_addr == tmr_off(i, OFF_CNT)) begin
                    bus_rdata = count[i];
                    mapped    = 1'b1;
                end
            end
            case (bus_addr)
                OFF_MASK: begin bus_rdata = DATA_W'(mask);        mapped = 1'b1; end
                OFF_RAW:  begin bus_rdata = DATA_W'(raw);         mapped = 1'b1; end
                OFF_MSKD: begin bus_rdata = DATA_W'(raw & mask);  mapped = 1'b1; end
                default: ;
            endcase
        end
    end

    // R1: misaligned offsets always read zero
    p_misaligned_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (rd && bus_addr[1:0] != 2'b00) |-> (bus_rdata == '0))
        else $error("misaligned read nonzero");

    // R7: a masked bit set at a clock edge drives irq
    p_irq_follows_r7: assert property (@(posedge clk) disable iff (rst)
        ((raw & mask) != '0) |-> irq)
        else $error("irq low with masked status");
endmodule

// File: tb/dual_countdown_timer_tb_top.sv
module dual_countdown_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  rate_tick = '0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    dual_countdown_timer dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rate_tick(rate_tick), .irq(irq)
    );

    // behavioural reference state
    logic [31:0] m_div [2];
    logic [31:0] m_cnt [2];
    logic [1:0]  m_op  [2];
    logic [2:0]  m_src [2];
    logic [1:0]  m_raw, m_mask;

    function automatic logic [31:0] mread(input logic [7:0] a);
        case (a)
            8'h04: return m_cnt[0];
            8'h14: return m_cnt[1];
            8'h48: return {30'd0, m_mask};
            8'h50: return {30'd0, m_raw};
            8'h54: return {30'd0, m_raw & m_mask};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h04, 8'h14: return "R4";
            8'h48, 8'h54: return "R7";
            8'h50:        return "R5";
            default:      return "R1";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step(input bit r, input bit s, input bit w, input logic [7:0] a,
                              input logic [31:0] d, input logic [3:0] t);
        logic [1:0] e;
        e = 2'b00;
        if (r) begin
            for (int i = 0; i < 2; i++) begin
                m_div[i] = 0; m_cnt[i] = 0; m_op[i] = 2'd1; m_src[i] = 3'd0;
            end
            m_raw = 0; m_mask = 0;
            return;
        end
        for (int i = 0; i < 2; i++) begin
            bit wc, wdv, tk;
            wc  = s && w && (a == 8'(8'h08 + 16 * i));
            wdv = s && w && (a == 8'(16 * i));
            tk  = (m_src[i] >= 3'd4) && t[m_src[i] - 3'd4];
            if (wc) begin
                if (d[1:0] == 2'd0) m_cnt[i] = m_div[i];
                m_op[i]  = d[1:0];
                m_src[i] = d[4:2];
            end else if (m_op[i] == 2'd2 && tk) begin
                if (m_cnt[i] == 0) begin m_cnt[i] = m_div[i]; e[i] = 1'b1; end
                else m_cnt[i] = m_cnt[i] - 1;
            end
            if (wdv) m_div[i] = d;
        end
        if (s && w && a == 8'h4C) m_raw = m_raw & ~d[1:0];
        m_raw = m_raw | e;
        if (s && w && a == 8'h48) m_mask = d[1:0];
    endtask

    // one clock: drive after falling edge, compare, advance model at rising edge
    task automatic cyc(input bit r, input bit s, input bit w, input logic [7:0] a,
                       input logic [31:0] d, input logic [3:0] t, input string tag = "");
        @(negedge clk);
        rst = r; bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d; rate_tick = t;
        #1;
        if (!rst) begin
            chk("R7", {31'd0, irq}, {31'd0, |(m_raw & m_mask)});
            if (s && !w) chk(tag == "" ? tag_of(a) : tag, bus_rdata, mread(a));
        end
        @(posedge clk);
        model_step(r, s, w, a, d, t);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] t = 4'd0);
        cyc(0, 1, 1, a, d, t);
    endtask

    task automatic rd(input logic [7:0] a, input string tag, input logic [3:0] t = 4'd0);
        cyc(0, 1, 0, a, 32'd0, t, tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] amap [12];
        amap = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h14, 8'h18,
                 8'h48, 8'h4C, 8'h50, 8'h54, 8'h20, 8'h06};
        repeat (3) cyc(1, 0, 0, 8'h00, 32'd0, 4'd0);
        // R8: reset state
        rd(8'h04, "R8"); rd(8'h14, "R8"); rd(8'h48, "R8"); rd(8'h50, "R8");
        chk("R8", {31'd0, irq}, 32'd0);

        // R2: load copies divisor
        wr(8'h00, 32'd3);
        wr(8'h08, 32'h10);            // load, src code 4
        rd(8'h04, "R2", 4'hF);
        chk("R2", bus_rdata, 32'd3);
        rd(8'h04, "R2", 4'hF);

        // R4: run on rate 0, count down and wrap
        wr(8'h08, 32'h12);
        for (int k = 0; k < 9; k++) rd(8'h04, "R4", 4'b0001);
        rd(8'h04, "R4", 4'b1110);     // unselected ticks
        rd(8'h50, "R5");
        chk("R5", bus_rdata, 32'd1);

        // R7: mask and irq
        wr(8'h48, 32'h1);
        rd(8'h54, "R7");
        chk("R7", {31'd0, irq}, 32'd1);

        // R3: hold and reserved code freeze
        wr(8'h08, 32'h11);
        for (int k = 0; k < 3; k++) rd(8'h04, "R3", 4'hF);
        wr(8'h08, 32'h13);
        for (int k = 0; k < 3; k++) rd(8'h04, "R3", 4'hF);

        // R6: acknowledge clears, then does not persist
        wr(8'h4C, 32'h1);
        rd(8'h50, "R6");
        chk("R6", bus_rdata, 32'd0);
        chk("R6", {31'd0, irq}, 32'd0);

        // R6: expiry wins against ack on timer B (rate 3, divisor 0)
        wr(8'h10, 32'd0);
        wr(8'h18, 32'h1E);
        rd(8'h50, "R5", 4'b1000);
        wr(8'h4C, 32'h2, 4'b1000);
        rd(8'h50, "R6");
        chk("R6", bus_rdata, 32'd2);
        wr(8'h4C, 32'h2);
        rd(8'h50, "R6");
        chk("R6", bus_rdata, 32'd0);

        // R9: control write overrides same-cycle tick
        wr(8'h10, 32'd5);
        wr(8'h18, 32'h1C, 4'b1000);   // load 5 while tick high
        rd(8'h14, "R9");
        chk("R9", bus_rdata, 32'd5);
        wr(8'h18, 32'h1E, 4'b1000);   // run, tick ignored this cycle
        rd(8'h14, "R9");
        chk("R9", bus_rdata, 32'd5);

        // R1: unmapped and write-only offsets
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h4A, 32'h3);
        rd(8'h20, "R1"); rd(8'h4A, "R1"); rd(8'h00, "R1"); rd(8'h18, "R1"); rd(8'h4C, "R1");
        rd(8'h48, "R1");

        // R10: mask write visible after next edge
        wr(8'h48, 32'h3);
        chk("R10", {30'd0, m_mask}, 32'd3);
        rd(8'h48, "R10");

        // mixed random traffic against the model
        for (int k = 0; k < 3000; k++) begin
            logic [7:0]  a;
            logic [31:0] d;
            a = amap[$urandom_range(0, 11)];
            d = (a[3:0] == 4'h8) ? 32'($urandom_range(0, 31)) : 32'($urandom_range(0, 4));
            if (k == 1500) cyc(1, 0, 0, 8'h00, 32'd0, 4'd0);
            else cyc(0, 1, $urandom_range(0, 3) == 0, a, d, 4'($urandom()));
        end
        rd(8'h04, "R8"); rd(8'h14, "R4"); rd(8'h54, "R7");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule